// File: doc/BRIEF.md
# Byte-wide SPI master on a CPU register bus

This block lets an 8-bit processor talk to a serial peripheral such as a memory card running in its SPI mode. The processor sees two registers, selected by a one-bit address. The data register holds the byte to send. After an exchange it holds the byte that came back. The control register holds three things: a chip-select bit that the software drives by hand, a bit that picks one of two serial clock rates, and a read-only ready flag.

Writing the data register while the block is ready starts an exchange of exactly eight bits. A single shift register sends its top bit on MOSI. Each bit sampled from MISO enters at the bottom end. The serial clock idles low. MISO is sampled on each rising SCLK edge, and the next MOSI bit is presented on the falling edge. The software polls the ready flag and then reads the received byte from the data register. Register reads are combinational and have no side effects.

The slow rate is meant for card initialisation, at roughly 400 kHz from the system clock. The fast rate is a small division of the system clock. Both are set as half-period counts in system clocks.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, and the control register reads 8'h80: ready (bit 7) is 1, the select bit is 0 and the slow rate is chosen.
- R2: A write to the control register (bus_addr 1) stores bit 0 as the select bit and bit 1 as the rate bit (1 means fast). Both read back in place. From the next cycle spi_cs_n equals the inverse of the stored select bit.
- R3: A write to the data register (bus_addr 0) while ready is 1 starts an exchange. Ready reads 0 in the cycle after the write.
- R4: MOSI carries the written byte most significant bit first. It is stable while SCLK is high.
- R5: MISO is sampled at each rising SCLK edge. After the exchange, the data register (bus_addr 0) reads the eight sampled bits, the first one sampled in bit 7.
- R6: Each exchange gives exactly eight SCLK pulses. SCLK is low whenever the block is ready and toggles only during an exchange.
- R7: Ready returns to 1 exactly 16*H clock cycles after the write that started the exchange. H is FAST_HALF when the rate bit is 1 and SLOW_HALF otherwise. Each SCLK high or low phase lasts H cycles.
- R8: A data register write while ready is 0 is ignored. The bits sent, the bits received and the completion time of the exchange in progress are all unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe for this block |
| bus_we | input | 1 | Write when 1, with bus_en |
| bus_addr | input | 1 | 0 selects the data register, 1 selects the control register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register, combinational |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The hardest situation to reach is a data write that arrives in the middle of a running exchange. To be ignored correctly, it must leave the shifter, the bit count and the clock divider untouched. The bench injects such a write at a chosen cycle, including cycles on SCLK edges. It then checks the serial stream captured by its slave model, the byte read back and the exact completion cycle. Random bytes and both rates are mixed with all-zero and all-one patterns, so that a bit-ordering or sampling-edge error shows up in the data.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  localparam int CTL_SEL_BIT   = 0;
  localparam int CTL_FAST_BIT  = 1;
  localparam int CTL_READY_BIT = 7;

  typedef struct packed {
    logic fast;
    logic sel;
  } ctrl_t;
endpackage

// File: rtl/spi_bm_regs.sv
module spi_bm_regs
  import spi_bm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rx_byte,
  output ctrl_t             ctrl,
  output logic              start,
  output logic [BYTE_W-1:0] start_byte,
  output logic [BYTE_W-1:0] bus_rdata
);
  logic wr_ctrl;
  logic wr_data;

  assign wr_ctrl    = bus_en && bus_we && (bus_addr == ADDR_CTRL);
  assign wr_data    = bus_en && bus_we && (bus_addr == ADDR_DATA);
  assign start      = wr_data && !busy;
  assign start_byte = bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl.sel  <= bus_wdata[CTL_SEL_BIT];
      ctrl.fast <= bus_wdata[CTL_FAST_BIT];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_CTRL) begin
      bus_rdata[CTL_SEL_BIT]   = ctrl.sel;
      bus_rdata[CTL_FAST_BIT]  = ctrl.fast;
      bus_rdata[CTL_READY_BIT] = !busy;
    end else begin
      bus_rdata = rx_byte;
    end
  end
endmodule

// File: rtl/spi_bm_clkgen.sv
module spi_bm_clkgen #(
  parameter int SLOW_HALF = 250,
  parameter int FAST_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int MAX_HALF = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int CNT_W = $clog2(MAX_HALF + 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_HALF - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_HALF - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = fast ? FAST_LAST : SLOW_LAST;
  assign tick = run && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_bm_shifter.sv
module spi_bm_shifter
  import spi_bm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] start_byte,
  input  logic              tick,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0]    shreg;
  logic [BIT_CNT_W-1:0] bit_cnt;
  logic                 sample;

  assign mosi    = shreg[BYTE_W-1];
  assign rx_byte = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
      sample  <= 1'b0;
      sclk    <= 1'b0;
      busy    <= 1'b0;
    end else if (start) begin
      shreg   <= start_byte;
      bit_cnt <= '0;
      sclk    <= 1'b0;
      busy    <= 1'b1;
    end else if (busy && tick) begin
      if (!sclk) begin
        sclk   <= 1'b1;
        sample <= miso;
      end else begin
        sclk    <= 1'b0;
        shreg   <= {shreg[BYTE_W-2:0], sample};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_bm_pkg::*;
#(
  parameter int SLOW_HALF = 250,
  parameter int FAST_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic       bus_we,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n
);
  ctrl_t             ctrl;
  logic              start;
  logic [BYTE_W-1:0] start_byte;
  logic              busy;
  logic              tick;
  logic [BYTE_W-1:0] rx_byte;

  spi_bm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy),
    .rx_byte(rx_byte), .ctrl(ctrl), .start(start),
    .start_byte(start_byte), .bus_rdata(bus_rdata)
  );

  spi_bm_clkgen #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(busy), .fast(ctrl.fast), .tick(tick)
  );

  spi_bm_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .start_byte(start_byte),
    .tick(tick), .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .busy(busy), .rx_byte(rx_byte)
  );

  assign spi_cs_n = !ctrl.sel;
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_en,
  input logic       bus_we,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic       spi_sclk,
  input logic       spi_mosi,
  input logic       spi_cs_n,
  input logic       busy,
  input logic       tick,
  input logic [7:0] rx_byte
);
  logic wr_d, wr_c;
  assign wr_d = bus_en && bus_we && !bus_addr;
  assign wr_c = bus_en && bus_we && bus_addr;

  a_r1_idle_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk);
  a_r2_cs_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c |=> (spi_cs_n == !$past(bus_wdata[0])));
  a_r3_start_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_d && !busy) |=> busy);
  a_r3_ready_falls_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_d));
  a_r4_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
  a_r6_sclk_moves_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_sclk) |-> $past(busy));
  a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_d && busy && !(tick && spi_sclk)) |=> $stable(rx_byte));
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .spi_sclk(spi_sclk),
  .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .busy(busy), .tick(tick),
  .rx_byte(rx_byte)
);

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;
  localparam int SH = 6;
  localparam int FH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0, bus_addr = 1'b1;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic spi_sclk, spi_mosi, spi_miso, spi_cs_n;

  logic [7:0] slv_sr = '0;
  logic [7:0] cap = '0;
  int pulses = 0;
  int n_chk = 0, n_fail = 0;
  int unsigned seed_dummy;

  always #2.5 clk = !clk;

  spi_byte_master #(.SLOW_HALF(SH), .FAST_HALF(FH)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  // mode-0 slave model
  assign spi_miso = slv_sr[7];
  always @(negedge spi_sclk) slv_sr <= {slv_sr[6:0], 1'b0};
  always @(posedge spi_sclk) begin
    cap <= {cap[6:0], spi_mosi};
    pulses <= pulses + 1;
  end

  function automatic int exp_cycles(input logic fast);
    return 16 * (fast ? FH : SH);
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = 1'b1;
    #1;
  endtask

  task automatic read_reg(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 1'b1;
  endtask

  // one exchange; inj >= 0 injects an ignored data write at that cycle
  task automatic xfer(input logic [7:0] tx, input logic [7:0] sl,
                      input logic fast, input int inj, input logic [7:0] junk);
    int n;
    logic [7:0] rd;
    bus_write(1'b1, {6'b0, fast, 1'b1});
    slv_sr = sl; cap = '0; pulses = 0;
    bus_write(1'b0, tx);
    check(bus_rdata[7] == 1'b0, "R3 ready low after start", bus_rdata[7], 0);
    n = 0;
    forever begin
      if (n == inj) begin
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = junk;
      end
      @(negedge clk);
      n++;
      bus_en = 1'b0; bus_we = 1'b0; bus_addr = 1'b1;
      #1;
      if (bus_rdata[7] || n > 4000) break;
    end
    check(n == exp_cycles(fast), inj >= 0 ? "R8 timing with ignored write" : "R7 completion cycle",
          n, exp_cycles(fast));
    check(pulses == 8 && spi_sclk == 1'b0, "R6 eight pulses, idle low", pulses, 8);
    check(cap == tx, inj >= 0 ? "R8 mosi unchanged by write" : "R4 mosi msb first", cap, tx);
    read_reg(1'b0, rd);
    check(rd == sl, inj >= 0 ? "R8 received byte unchanged" : "R5 received byte", rd, sl);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    seed_dummy = $urandom(32'h5eed1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(spi_cs_n == 1'b1, "R1 cs deasserted", spi_cs_n, 1);
    check(spi_sclk == 1'b0, "R1 sclk low", spi_sclk, 0);
    read_reg(1'b1, rd);
    check(rd == 8'h80, "R1 control reset value", rd, 8'h80);

    // R2 control register
    bus_write(1'b1, 8'h03);
    check(spi_cs_n == 1'b0, "R2 cs asserted", spi_cs_n, 0);
    read_reg(1'b1, rd);
    check(rd == 8'h83, "R2 control readback", rd, 8'h83);
    bus_write(1'b1, 8'h00);
    check(spi_cs_n == 1'b1, "R2 cs released", spi_cs_n, 1);
    read_reg(1'b1, rd);
    check(rd == 8'h80, "R2 control cleared", rd, 8'h80);

    // directed corner patterns, both rates
    xfer(8'h00, 8'hFF, 1'b0, -1, 8'h00);
    xfer(8'hFF, 8'h00, 1'b1, -1, 8'h00);
    xfer(8'hA5, 8'h3C, 1'b1, -1, 8'h00);
    xfer(8'h81, 8'h7E, 1'b0, -1, 8'h00);

    // R8 ignored writes at several phases
    xfer(8'hC3, 8'h5A, 1'b0, 3, 8'h18);
    xfer(8'h96, 8'hE1, 1'b0, SH, 8'h7F);
    xfer(8'h0F, 8'hF0, 1'b1, 1, 8'hAA);
    xfer(8'h12, 8'h34, 1'b1, exp_cycles(1'b1) - 1, 8'hEE);

    // random exchanges
    for (int i = 0; i < 40; i++) begin
      logic [7:0] t, s;
      logic f;
      int j;
      t = 8'($urandom); s = 8'($urandom); f = 1'($urandom);
      j = ($urandom % 4 == 0) ? int'($urandom % exp_cycles(f)) : -1;
      xfer(t, s, f, j, 8'($urandom));
    end

    bus_write(1'b1, 8'h00);
    check(spi_cs_n == 1'b1, "R2 cs released at end", spi_cs_n, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule